// File: doc/BRIEF.md
# Load-Use Stall and Redirect Squash Controller

This block is the hazard control for a five-stage in-order pipeline. It looks at the instruction now in execute and the instruction now in decode. When the execute instruction is a memory load whose destination register is a source of the decode instruction, the block inserts one bubble. It holds the program counter and the fetch/decode register for one cycle. It also tells the decode stage to send all-zero control bits into execute, so a no-operation moves forward. Instructions already past decode keep moving while this happens.

The block also handles control transfers, which are resolved in decode. A jump in decode, or a branch in decode whose comparator reports taken, squashes the one instruction fetched behind it on the sequential path. The block does this by raising a one-cycle flush that clears the fetch/decode register's instruction field. In that same cycle the program counter loads the target. Branches are assumed not taken until decode says otherwise.

Every output is a combinational function of the current inputs and one internal flag. The flag remembers that a stall was issued on the previous cycle.

Top module: `hazard_ctl`

## Requirements
- R1: Reset behaviour. While reset is held with no load in execute and a non-control instruction in decode, the outputs are pc_we=1, ifid_we=1, ctl_zero=0, if_flush=0.
- R2: Stall on the rs source. If ex_mem_rd=1, ex_rt is nonzero and ex_rt equals id_rs, then in the same cycle pc_we=0, ifid_we=0 and ctl_zero=1.
- R3: Stall on the rt source. The outputs of R2 also appear when ex_mem_rd=1, ex_rt is nonzero and ex_rt equals id_rt.
- R4: No load, no stall. When ex_mem_rd=0 the block never stalls, whatever the register numbers are.
- R5: Register zero never stalls. A load whose ex_rt is 0 causes no stall, even when the register numbers match.
- R6: No match, no stall. A load whose ex_rt equals neither id_rs nor id_rt causes no stall: pc_we=1, ifid_we=1, ctl_zero=0.
- R7: One bubble per load. In the cycle after a stall cycle, the block does not stall, even if the inputs still match. Any flush that the decode instruction calls for is applied in that cycle.
- R8: Jump squash. When id_kind=2'b10 (jump) and there is no stall, if_flush=1 while pc_we=1 and ifid_we=1, so the target loads in the same cycle.
- R9: Branch squash. When id_kind=2'b01 (branch), if_flush equals br_taken, provided there is no stall.
- R10: Stall wins over squash. When a stall condition holds and decode holds a jump or branch, if_flush=0 and the stall outputs of R2 are produced.
- R11: Other instructions never squash. For id_kind 2'b00 or 2'b11, if_flush=0 whatever br_taken is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_mem_rd | input | 1 | Execute-stage instruction reads data memory (a load) |
| ex_rt | input | RW | Destination register number of the execute-stage load |
| id_rs | input | RW | First source register number in decode |
| id_rt | input | RW | Second source register number in decode |
| id_kind | input | 2 | Decode class: 00 other, 01 branch, 10 jump, 11 other |
| br_taken | input | 1 | Decode-stage branch comparator says taken |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| ctl_zero | output | 1 | Decode mux selects all-zero control bits |
| if_flush | output | 1 | Clear the instruction field of the fetch/decode register |

## Verification
Each stall and squash output is due in the same cycle as the inputs that cause it. The bench therefore changes the inputs on the falling edge and samples the outputs one nanosecond later. The one-bubble limit of R7 only shows after the rising edge that follows a stall cycle. For that case the bench holds the same inputs across that edge and samples again after the next falling edge. The sweep covers every combination of a two-bit register field, every decode class and both branch results. Before each combination the bench spends one idle cycle to clear the stall memory, so each case starts from a known state.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_mem_rd,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [1:0]    id_kind,
  input  logic          br_taken,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ctl_zero,
  output logic          if_flush
);
  localparam logic [1:0]    K_BR  = 2'b01;
  localparam logic [1:0]    K_JMP = 2'b10;
  localparam logic [RW-1:0] ZREG  = '0;

  logic stall_q;
  logic src_hit;
  logic load_hz;
  logic redirect;

  assign src_hit  = (ex_rt == id_rs) || (ex_rt == id_rt);
  assign load_hz  = ex_mem_rd && (ex_rt != ZREG) && src_hit && !stall_q;
  assign redirect = (id_kind == K_JMP) || ((id_kind == K_BR) && br_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= load_hz;
  end

  assign pc_we    = !load_hz;
  assign ifid_we  = !load_hz;
  assign ctl_zero = load_hz;
  assign if_flush = redirect && !load_hz;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_mem_rd,
  input logic [RW-1:0] ex_rt,
  input logic [RW-1:0] id_rs,
  input logic [RW-1:0] id_rt,
  input logic [1:0]    id_kind,
  input logic          br_taken,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          ctl_zero,
  input logic          if_flush
);
  p_rs_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_rt != '0 && ex_rt == id_rs && !$past(ctl_zero)) |-> (!pc_we && !ifid_we && ctl_zero));

  p_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_rd |-> (pc_we && ifid_we && !ctl_zero));

  p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rt == '0) |-> !ctl_zero);

  p_one_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero |=> !ctl_zero);

  p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (id_kind == 2'b10 || (id_kind == 2'b01 && br_taken)));

  p_stall_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero |-> !if_flush);

  p_flush_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (pc_we && ifid_we));
endmodule

bind hazard_ctl hazard_ctl_chk #(.RW(RW)) u_chk (.*);

// File: tb/hazard_ctl_test.sv
`timescale 1ns/1ps
module hazard_ctl_test;
  localparam int TW = 2;
  localparam int NR = 1 << TW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_mem_rd = 1'b0;
  logic [TW-1:0] ex_rt = '0, id_rs = '0, id_rt = '0;
  logic [1:0] id_kind = 2'b00;
  logic br_taken = 1'b0;
  logic pc_we, ifid_we, ctl_zero, if_flush;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hazard_ctl #(.RW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .ex_mem_rd(ex_mem_rd), .ex_rt(ex_rt),
    .id_rs(id_rs), .id_rt(id_rt), .id_kind(id_kind), .br_taken(br_taken),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctl_zero(ctl_zero), .if_flush(if_flush)
  );

  function automatic logic [3:0] model(input logic mr, input int e, input int s,
                                       input int t, input int k, input logic bt,
                                       input logic after_stall);
    logic hz, rd;
    hz = mr && (e != 0) && (e == s || e == t) && !after_stall;
    rd = (k == 2) || (k == 1 && bt);
    return {!hz, !hz, hz, rd && !hz};
  endfunction

  function automatic string tag_of(input logic mr, input int e, input int s,
                                   input int t, input int k, input logic bt);
    logic hit;
    hit = (e == s) || (e == t);
    if (mr && e != 0 && hit) begin
      if (k == 1 || k == 2) return "R10";
      return (e == s) ? "R2" : "R3";
    end
    if (!mr) return "R4";
    if (e == 0 && hit) return "R5";
    if (k == 2) return "R8";
    if (k == 1) return "R9";
    if (bt) return "R11";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_we, ifid_we, ctl_zero, if_flush};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pc_we,ifid_we,ctl_zero,if_flush} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R1", 4'b1100);
    @(negedge clk);
    rst_n = 1'b1;
    for (int mr = 0; mr < 2; mr++)
      for (int e = 0; e < NR; e++)
        for (int s = 0; s < NR; s++)
          for (int t = 0; t < NR; t++)
            for (int k = 0; k < 4; k++)
              for (int bt = 0; bt < 2; bt++) begin
                ex_mem_rd = 1'b0;
                id_kind = 2'b00;
                @(negedge clk);
                ex_mem_rd = mr[0];
                ex_rt = TW'(e);
                id_rs = TW'(s);
                id_rt = TW'(t);
                id_kind = 2'(k);
                br_taken = bt[0];
                #1 check(tag_of(mr[0], e, s, t, k, bt[0]), model(mr[0], e, s, t, k, bt[0], 1'b0));
                if (model(mr[0], e, s, t, k, bt[0], 1'b0) == 4'b0010) begin
                  @(negedge clk);
                  #1 check("R7", model(mr[0], e, s, t, k, bt[0], 1'b1));
                end
              end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule